// File: doc/BRIEF.md
# Frame-Synchronised Serial DAC Code Receiver

This block takes DAC codes from a three-wire synchronous serial link and turns them into a parallel code with a one-cycle update strobe. The link has a serial clock, a data line and an active-low frame line. The frame source sits outside the block. It may be a processor serial port or a strobe shared with an ADC. The serial clock may run without pause, because only edges inside a frame are counted.

All three link wires are brought into the system clock domain through a synchroniser. Within a frame, the data line is sampled on each falling serial-clock edge, most significant bit first. On the sixteenth such edge, the low fourteen bits of the word are loaded into the DAC latch, which behaves as though its load control were tied active. The update strobe marks the cycle in which the new code first appears.

The code output uses a stream-style valid signal with no ready. The serial link has no flow control, so back-pressure cannot exist. The consumer must take the code on every cycle in which `dac_upd_o` is high. The code stays on `dac_code_o` until the next complete frame.

Top module: `sdac_rx`

## Requirements
- R1: After reset, `dac_code_o` is 0 and `dac_upd_o` is 0.
- R2: While `sync_n_i` is low, each falling edge of `sclk_i` samples `sdata_i`, most significant bit first. On the sixteenth counted edge, `dac_code_o` takes bits 13:0 of the received 16-bit word. The first bit received is bit 15.
- R3: `dac_upd_o` is high for exactly one clock cycle per completed frame. It is high in the cycle in which the new code first appears. It rises on the fourth rising `clk` edge counted from the first rising edge that samples `sclk_i` low for the sixteenth fall. This count applies with the default two synchroniser stages.
- R4: If `sync_n_i` rises before sixteen edges have been counted, the partial word is dropped. `dac_code_o` keeps its previous value and no strobe is produced.
- R5: Falling `sclk_i` edges after the sixteenth in the same frame are ignored until `sync_n_i` goes high and then low again.
- R6: Falling `sclk_i` edges while `sync_n_i` is high are ignored. They cause no strobe and no code change, and they do not contribute bits to the next frame.
- R7: Every falling edge of `sync_n_i` restarts the bit count at zero. A frame that follows an aborted one therefore receives a complete fresh word.
- R8: Bits 15 and 14 of the word have no effect on `dac_code_o`.
- R9: `dac_code_o` changes only in a cycle in which `dac_upd_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sync_n_i | input | 1 | Active-low frame signal |
| sdata_i | input | 1 | Serial data, most significant bit first |
| dac_code_o | output | 14 | DAC latch contents |
| dac_upd_o | output | 1 | One-cycle valid strobe for a new code |

## Verification
On every cycle, the assertions check the following properties:
- The bit counter never passes sixteen, and a frame that has already completed cannot load again.
- A load only comes from inside a frame.
- The update strobe never lasts more than one cycle.
- The code never moves without the strobe.

Some behaviours can only be shown by the bench's scenarios, which compare against a cycle-accurate model:
- The bit order and which bits reach the code.
- Exact strobe latency.
- Discarding of aborted frames.
- Immunity to idle and surplus clock edges.
- The count restarting on a new frame.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  // Serial word length and the DAC code carried in its low bits
  localparam int unsigned SDAC_WORD_W = 16;
  localparam int unsigned SDAC_CODE_W = 14;
  // Flip-flops between the pins and the edge logic
  localparam int unsigned SDAC_SYNC_DEPTH = 2;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s_i,
  input  logic sync_n_s_i,
  output logic sclk_fall_o,
  output logic frame_start_o,
  output logic frame_on_o
);
  logic sclk_prev_q;
  logic sync_prev_q;

  // Both lines idle high, so reset must not create a false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b1;
      sync_prev_q <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_s_i;
      sync_prev_q <= sync_n_s_i;
    end
  end

  assign sclk_fall_o   = sclk_prev_q & ~sclk_s_i;
  assign frame_start_o = sync_prev_q & ~sync_n_s_i;
  assign frame_on_o    = ~sync_n_s_i;
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_fall_i,
  input  logic              frame_start_i,
  input  logic              frame_on_i,
  input  logic              sdata_s_i,
  output logic              word_vld_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(WORD_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shreg_q;
  logic [WORD_W-1:0] next_word;
  logic              take_bit;

  // A bit is taken only inside a frame, never on the restart cycle, and not past the end of the word
  assign take_bit  = frame_on_i & ~frame_start_i & sclk_fall_i & (cnt_q < FULL);
  assign next_word = {shreg_q[WORD_W-2:0], sdata_s_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      shreg_q    <= '0;
      word_vld_o <= 1'b0;
      code_o     <= '0;
    end else begin
      word_vld_o <= 1'b0;
      if (frame_start_i || !frame_on_i) begin
        cnt_q <= '0;
      end else if (take_bit) begin
        shreg_q <= next_word;
        cnt_q   <= cnt_q + 1'b1;
        if (cnt_q == LAST_BIT) begin
          word_vld_o <= 1'b1;
          code_o     <= next_word[CODE_W-1:0];
        end
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);                                              // R5
  AST_DONE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == FULL) |=> !word_vld_o);                            // R5
  AST_LOAD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |-> $past(frame_on_i));                           // R2
endmodule

// File: rtl/sdac_rx.sv
module sdac_rx #(
  parameter int unsigned WORD_W = sdac_pkg::SDAC_WORD_W,
  parameter int unsigned CODE_W = sdac_pkg::SDAC_CODE_W,
  parameter int unsigned SYNC_DEPTH = sdac_pkg::SDAC_SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sync_n_i,
  input  logic              sdata_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              dac_upd_o
);
  logic [2:0]        pins_s;
  logic              sclk_fall, frame_start, frame_on;
  logic              word_vld;
  logic [CODE_W-1:0] word_code;

  // Bit order in pins_s: [2]=serial clock, [1]=frame, [0]=data
  sdac_sync #(.WIDTH(3), .STAGES(SYNC_DEPTH), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({sclk_i, sync_n_i, sdata_i}),
    .q_o(pins_s)
  );

  sdac_edge u_edge (
    .clk(clk), .rst_n(rst_n),
    .sclk_s_i(pins_s[2]), .sync_n_s_i(pins_s[1]),
    .sclk_fall_o(sclk_fall), .frame_start_o(frame_start), .frame_on_o(frame_on)
  );

  sdac_shift #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_fall_i(sclk_fall), .frame_start_i(frame_start), .frame_on_i(frame_on),
    .sdata_s_i(pins_s[0]),
    .word_vld_o(word_vld), .code_o(word_code)
  );

  // DAC latch: always loads on a completed word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code_o <= '0;
      dac_upd_o  <= 1'b0;
    end else begin
      dac_upd_o <= word_vld;
      if (word_vld) dac_code_o <= word_code;
    end
  end

  AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_upd_o |=> !dac_upd_o);                                   // R3
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_upd_o |-> $stable(dac_code_o));                         // R9
endmodule

// File: tb/sdac_rx_test.sv
`timescale 1ns/1ps
module sdac_rx_test;
  localparam int LAT = 3;  // two synchroniser stages plus the latch stage

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sync_n = 1'b1, sdata = 1'b0;
  logic [13:0] dac_code;
  logic dac_upd;

  int nchk = 0, nfail = 0, cyc = 0;
  int upd_cnt = 0, upd_cyc = 0, fall_cyc = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  sdac_rx uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sync_n_i(sync_n), .sdata_i(sdata),
    .dac_code_o(dac_code), .dac_upd_o(dac_upd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference: processes raw samples, delivers results LAT edges later
  logic [13:0] q_code [$];
  logic        q_upd  [$];
  logic [13:0] m_code, exp_code;
  logic [15:0] m_word;
  int          m_bits;
  logic        m_prev_sclk, m_prev_sync, exp_upd;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q_code.delete(); q_upd.delete();
      for (int i = 0; i < LAT; i++) begin q_code.push_back(14'd0); q_upd.push_back(1'b0); end
      m_code = 0; m_word = 0; m_bits = 0; m_prev_sclk = 1; m_prev_sync = 1;
      exp_code = 0; exp_upd = 0;
    end else begin
      logic evt;
      evt = 1'b0;
      if ((m_prev_sync && !sync_n) || sync_n) m_bits = 0;
      else if (m_prev_sclk && !sclk && m_bits < 16) begin
        m_word = {m_word[14:0], sdata};
        m_bits++;
        if (m_bits == 16) begin evt = 1'b1; m_code = m_word[13:0]; end
      end
      m_prev_sclk = sclk; m_prev_sync = sync_n;
      q_code.push_back(m_code); q_upd.push_back(evt);
      exp_code = q_code.pop_front();
      exp_upd  = q_upd.pop_front();
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    chk({cur_tag, " code"}, 32'(dac_code), 32'(exp_code));
    chk({cur_tag, " upd"}, 32'(dac_upd), 32'(exp_upd));
    if (dac_upd) begin upd_cnt++; upd_cyc = cyc; end
  end

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input logic d);
    sdata = d; sclk = 1'b1;
    wait_neg(3);
    sclk = 1'b0; fall_cyc = cyc;
    wait_neg(3);
  endtask

  task automatic frame(input logic [15:0] w, input int nticks);
    sync_n = 1'b0;
    wait_neg(3);
    for (int i = 0; i < nticks; i++) tick(i < 16 ? w[15-i] : 1'b1);
    wait_neg(3);
    sync_n = 1'b1;
    wait_neg(8);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    int base;
    wait_neg(4);
    chk("R1 reset code", 32'(dac_code), 0);
    chk("R1 reset upd", 32'(dac_upd), 0);
    rst_n = 1'b1;
    wait_neg(4);

    cur_tag = "R2";
    base = upd_cnt;
    frame(16'h5A3C, 16);
    chk("R2 code", 32'(dac_code), 32'h1A3C);
    chk("R3 one strobe", 32'(upd_cnt - base), 1);
    chk("R3 latency", 32'(upd_cyc - fall_cyc), 4);

    cur_tag = "R8";
    frame(16'hC001, 16);
    chk("R8 top bits ignored", 32'(dac_code), 32'h0001);
    frame(16'h3FFF, 16);
    chk("R2 all ones", 32'(dac_code), 32'h3FFF);

    cur_tag = "R4";
    base = upd_cnt;
    sync_n = 1'b0; wait_neg(3);
    for (int i = 0; i < 10; i++) tick(i[0]);
    sync_n = 1'b1; wait_neg(8);
    chk("R4 abort keeps code", 32'(dac_code), 32'h3FFF);
    chk("R4 abort no strobe", 32'(upd_cnt - base), 0);

    cur_tag = "R5";
    base = upd_cnt;
    frame(16'h0155, 21);
    chk("R5 extra edges ignored", 32'(dac_code), 32'h0155);
    chk("R5 single strobe", 32'(upd_cnt - base), 1);

    cur_tag = "R6";
    base = upd_cnt;
    for (int i = 0; i < 20; i++) tick(1'b1);
    chk("R6 idle edges no strobe", 32'(upd_cnt - base), 0);
    chk("R9 code held while idle", 32'(dac_code), 32'h0155);
    frame(16'h8123, 16);
    chk("R6 frame after idle clock", 32'(dac_code), 32'h0123);

    cur_tag = "R7";
    base = upd_cnt;
    sync_n = 1'b0; wait_neg(3);
    for (int i = 0; i < 5; i++) tick(1'b1);
    sync_n = 1'b1; wait_neg(4);
    frame(16'h2AAA, 16);
    chk("R7 restart full word", 32'(dac_code), 32'h2AAA);
    chk("R7 one strobe", 32'(upd_cnt - base), 1);

    cur_tag = "R9";
    wait_neg(20);
    chk("R9 hold", 32'(dac_code), 32'h2AAA);

    summary();
    $finish;
  end
endmodule